// File: doc/BRIEF.md
# Floating-Point Exception Status Unit

This unit reports exceptions for a numeric coprocessor. The execution datapath sends one completion strobe for each instruction. With the strobe comes a request vector for the six arithmetic exception conditions. The unit compares the requests against the six mask bits of its control word. It records the result as sticky flags in its status word. It keeps an error summary bit, and from it drives an active-low error line to the host processor.

An error that is not masked is not delivered at once. It stays pending until the host issues its next escape or wait operation. That operation then raises an interrupt-16 request in place of proceeding. At each non-control instruction the unit also records the 20-bit instruction address, the 11-bit opcode and the 20-bit operand address, so that a handler can find the faulting instruction. The flags are cleared only by an explicit clear command.

Top module: `fpx_exc_unit`

## Requirements
- R1: After synchronous reset the six flags are 0, all six mask bits are 1, status bit 7 is 0, `err_n` is 1, `int16` is 0 and all pointer outputs are 0.
- R2: When `cw_wr` is high at a clock edge, `mask_o` shows `cw_mask` from the next cycle on. A 1 in a mask bit masks that condition.
- R3: Status bits 0 to 5 are invalid, denormal, zero-divide, overflow, underflow and precision, in that order. Precedence is the same order, with bit 0 highest. When `insn_done` is high, only the lowest-numbered unmasked requested condition sets its flag, and any other unmasked requests of that instruction are dropped.
- R4: A masked request sets its own flag when `insn_done` is high. It does not set status bit 7 and does not drive `err_n` low.
- R5: An unmasked request accepted at an edge sets its flag, sets status bit 7 and drives `err_n` low in the next cycle.
- R6: The flags are sticky. `clr_exc` zeroes all of them for the next cycle. Requests accepted in the same cycle as `clr_exc` are still recorded.
- R7: Status bit 7 is the OR over all bits of (flag AND NOT mask), and `err_n` is its inverse. A change of mask alone updates both in the cycle the new mask appears.
- R8: If `host_esc` is high at an edge while status bit 7 is 1, `int16` is 1 for the next cycle. Otherwise `int16` is 0 in the next cycle.
- R9: On `insn_done` with `is_ctrl` low, the next cycle shows the following:
  - `ip_lo`/`ip_hi` hold bits 15:0 and 19:16 of `insn_addr`.
  - `opc_o` holds `insn_opc`.
  - `dp_lo`/`dp_hi` hold bits 15:0 and 19:16 of `opnd_addr`, or zero when `has_opnd` is low.
- R10: A control instruction (`is_ctrl` high) leaves all pointer outputs unchanged, although its requests are still handled by R3 to R5.
- R11: Status bit 6 is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_done | input | 1 | An instruction completes this cycle |
| exc_req | input | 6 | Exception requests of that instruction |
| is_ctrl | input | 1 | The completing instruction is a control instruction |
| insn_addr | input | 20 | Address of the completing instruction |
| insn_opc | input | 11 | Opcode of the completing instruction |
| has_opnd | input | 1 | The instruction has a memory operand |
| opnd_addr | input | 20 | Operand address |
| cw_wr | input | 1 | Load mask bits |
| cw_mask | input | 6 | New mask bits |
| clr_exc | input | 1 | Clear all exception flags |
| host_esc | input | 1 | Host issues an escape or wait operation |
| status_o | output | 8 | Flags [5:0], bit 6 zero, error summary bit 7 |
| mask_o | output | 6 | Current mask bits |
| err_n | output | 1 | Active-low error line |
| int16 | output | 1 | Interrupt-16 request |
| ip_lo | output | 16 | Instruction address bits 15:0 |
| ip_hi | output | 4 | Instruction address bits 19:16 |
| opc_o | output | 11 | Opcode |
| dp_lo | output | 16 | Operand address bits 15:0 |
| dp_hi | output | 4 | Operand address bits 19:16 |

## Verification
A flag register in the wrong state becomes visible on `status_o` in the cycle after the edge that loaded it. Because the summary is combinational, it also reaches `err_n` in that same cycle. A wrong mask bit may stay hidden until a matching flag is set, and then it shows as an error line that is wrong in the same cycle. A wrong pending state shows only one cycle after the host's next escape, through `int16`. For this reason the bench compares every output against its model on every clock.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
    localparam int NUM_EXC = 6;
    localparam int ADDR_W  = 20;
    localparam int LO_W    = 16;
    localparam int HI_W    = ADDR_W - LO_W;
    localparam int OPC_W   = 11;
    localparam int SW_W    = 8;
    localparam int ES_BIT  = SW_W - 1;

    typedef logic [NUM_EXC-1:0] exc_vec_t;

    // bit index equals precedence rank, 0 is highest
    typedef enum logic [2:0] {
        EXC_INV  = 3'd0,
        EXC_DEN  = 3'd1,
        EXC_ZDIV = 3'd2,
        EXC_OVF  = 3'd3,
        EXC_UNF  = 3'd4,
        EXC_PREC = 3'd5
    } exc_id_e;

    typedef struct packed {
        logic [LO_W-1:0]  ip_lo;
        logic [HI_W-1:0]  ip_hi;
        logic [OPC_W-1:0] opc;
        logic [LO_W-1:0]  dp_lo;
        logic [HI_W-1:0]  dp_hi;
    } ptr_img_t;

    // one-hot of the lowest-numbered set bit (highest precedence)
    function automatic exc_vec_t pick_first(input exc_vec_t v);
        exc_vec_t r;
        logic     seen;
        r    = '0;
        seen = 1'b0;
        for (int i = 0; i < NUM_EXC; i++) begin
            if (v[i] && !seen) begin
                r[i] = 1'b1;
                seen = 1'b1;
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/fpx_prio_sel.sv
module fpx_prio_sel
    import fpx_pkg::*;
(
    input  exc_vec_t req,
    input  exc_vec_t mask,
    output exc_vec_t set_vec
);
    exc_vec_t masked_hits;
    exc_vec_t unmasked_hits;

    always_comb begin
        masked_hits   = req & mask;
        unmasked_hits = req & ~mask;
        set_vec       = masked_hits | pick_first(unmasked_hits);
    end
endmodule

// File: rtl/fpx_status_reg.sv
module fpx_status_reg
    import fpx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     apply,
    input  exc_vec_t set_vec,
    input  logic     clr,
    input  logic     mask_wr,
    input  exc_vec_t mask_wdata,
    output exc_vec_t flags,
    output exc_vec_t mask,
    output logic     es
);
    exc_vec_t pend_terms;

    for (genvar g = 0; g < NUM_EXC; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                flags[g] <= 1'b0;
                mask[g]  <= 1'b1;
            end else begin
                flags[g] <= (flags[g] & ~clr) | (apply & set_vec[g]);
                if (mask_wr)
                    mask[g] <= mask_wdata[g];
            end
        end
        assign pend_terms[g] = flags[g] & ~mask[g];
    end

    assign es = |pend_terms;
endmodule

// File: rtl/fpx_ptr_capture.sv
module fpx_ptr_capture
    import fpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap,
    input  logic [ADDR_W-1:0] iaddr,
    input  logic [OPC_W-1:0]  opc,
    input  logic              has_opnd,
    input  logic [ADDR_W-1:0] daddr,
    output ptr_img_t          img
);
    logic [ADDR_W-1:0] dsel;

    assign dsel = has_opnd ? daddr : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            img <= '0;
        end else if (cap) begin
            img.ip_lo <= iaddr[LO_W-1:0];
            img.ip_hi <= iaddr[ADDR_W-1:LO_W];
            img.opc   <= opc;
            img.dp_lo <= dsel[LO_W-1:0];
            img.dp_hi <= dsel[ADDR_W-1:LO_W];
        end
    end
endmodule

// File: rtl/fpx_exc_unit.sv
module fpx_exc_unit
    import fpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              insn_done,
    input  logic [5:0]        exc_req,
    input  logic              is_ctrl,
    input  logic [19:0]       insn_addr,
    input  logic [10:0]       insn_opc,
    input  logic              has_opnd,
    input  logic [19:0]       opnd_addr,
    input  logic              cw_wr,
    input  logic [5:0]        cw_mask,
    input  logic              clr_exc,
    input  logic              host_esc,
    output logic [7:0]        status_o,
    output logic [5:0]        mask_o,
    output logic              err_n,
    output logic              int16,
    output logic [15:0]       ip_lo,
    output logic [3:0]        ip_hi,
    output logic [10:0]       opc_o,
    output logic [15:0]       dp_lo,
    output logic [3:0]        dp_hi
);
    exc_vec_t set_vec;
    exc_vec_t flags;
    exc_vec_t mask;
    logic     es;
    ptr_img_t img;
    logic     int16_q;

    fpx_prio_sel u_sel (
        .req     (exc_req),
        .mask    (mask),
        .set_vec (set_vec)
    );

    fpx_status_reg u_stat (
        .clk        (clk),
        .rst        (rst),
        .apply      (insn_done),
        .set_vec    (set_vec),
        .clr        (clr_exc),
        .mask_wr    (cw_wr),
        .mask_wdata (cw_mask),
        .flags      (flags),
        .mask       (mask),
        .es         (es)
    );

    fpx_ptr_capture u_ptr (
        .clk      (clk),
        .rst      (rst),
        .cap      (insn_done & ~is_ctrl),
        .iaddr    (insn_addr),
        .opc      (insn_opc),
        .has_opnd (has_opnd),
        .daddr    (opnd_addr),
        .img      (img)
    );

    always_ff @(posedge clk) begin
        if (rst) int16_q <= 1'b0;
        else     int16_q <= host_esc & es;
    end

    always_comb begin
        status_o                = '0;
        status_o[NUM_EXC-1:0]   = flags;
        status_o[ES_BIT]        = es;
    end

    assign mask_o = mask;
    assign err_n  = ~es;
    assign int16  = int16_q;
    assign ip_lo  = img.ip_lo;
    assign ip_hi  = img.ip_hi;
    assign opc_o  = img.opc;
    assign dp_lo  = img.dp_lo;
    assign dp_hi  = img.dp_hi;
endmodule

// File: rtl/fpx_exc_chk.sv
module fpx_exc_chk (
    input logic        clk,
    input logic        rst,
    input logic        insn_done,
    input logic [5:0]  exc_req,
    input logic        is_ctrl,
    input logic [19:0] insn_addr,
    input logic        cw_wr,
    input logic [5:0]  cw_mask,
    input logic        clr_exc,
    input logic        host_esc,
    input logic [7:0]  status_o,
    input logic [5:0]  mask_o,
    input logic        err_n,
    input logic        int16,
    input logic [15:0] ip_lo
);
    // R6
    flags_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_exc |=> ((status_o[5:0] & $past(status_o[5:0])) == $past(status_o[5:0])));

    // R6
    clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_exc && !insn_done) |=> (status_o[5:0] == 6'd0));

    // R3
    one_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (insn_done && !cw_wr && !clr_exc) |=>
        ($countones(status_o[5:0] & ~$past(status_o[5:0]) & ~mask_o) <= 1));

    // R8
    int16_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (host_esc && !err_n) |=> int16);

    // R8
    int16_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !host_esc |=> !int16);

    // R7
    err_line_chk: assert property (@(posedge clk) disable iff (rst)
        err_n == !status_o[7]);

    // R11
    bit6_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !status_o[6]);

    // R2
    mask_load_chk: assert property (@(posedge clk) disable iff (rst)
        cw_wr |=> (mask_o == $past(cw_mask)));

    // R9
    ip_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (insn_done && !is_ctrl) |=> (ip_lo == $past(insn_addr[15:0])));

    // R10
    ip_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(insn_done && !is_ctrl) |=> $stable(ip_lo));

    // R4
    masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (insn_done && err_n && ((exc_req & ~mask_o) == 6'd0) && !cw_wr) |=> err_n);
endmodule

bind fpx_exc_unit fpx_exc_chk u_chk (.*);

// File: tb/tb_fpx_exc_unit.sv
module tb_fpx_exc_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        insn_done, is_ctrl, has_opnd, cw_wr, clr_exc, host_esc;
    logic [5:0]  exc_req, cw_mask;
    logic [19:0] insn_addr, opnd_addr;
    logic [10:0] insn_opc;
    logic [7:0]  status_o;
    logic [5:0]  mask_o;
    logic        err_n, int16;
    logic [15:0] ip_lo, dp_lo;
    logic [3:0]  ip_hi, dp_hi;
    logic [10:0] opc_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // model state
    int m_flags, m_mask, m_int16, m_ip, m_opc, m_dp;

    always #4 clk = ~clk;

    fpx_exc_unit dut (.*);

    function automatic int m_es();
        return ((m_flags & ~m_mask & 6'h3f) != 0) ? 1 : 0;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("R3 flags", int'(status_o[5:0]), m_flags);
        check("R7 summary", int'(status_o[7]), m_es());
        check("R11 bit6", int'(status_o[6]), 0);
        check("R5 err_n", int'(err_n), 1 - m_es());
        check("R2 mask", int'(mask_o), m_mask);
        check("R8 int16", int'(int16), m_int16);
        check("R9 ip", int'({ip_hi, ip_lo}), m_ip);
        check("R9 opc", int'(opc_o), m_opc);
        check("R9 dp", int'({dp_hi, dp_lo}), m_dp);
    endtask

    // advance one clock: update model from inputs seen at the edge, then compare
    task automatic tick();
        int unm, first, nw;
        @(posedge clk);
        if (rst) begin
            m_flags = 0; m_mask = 'h3f; m_int16 = 0; m_ip = 0; m_opc = 0; m_dp = 0;
        end else begin
            m_int16 = (host_esc && m_es() != 0) ? 1 : 0;
            nw = 0;
            if (insn_done) begin
                unm = exc_req & ~m_mask & 'h3f;
                first = 0;
                for (int i = 0; i < 6; i++)
                    if (first == 0 && unm[i]) first = 1 << i;
                nw = (exc_req & m_mask) | first;
                if (!is_ctrl) begin
                    m_ip = insn_addr; m_opc = insn_opc;
                    m_dp = has_opnd ? opnd_addr : 0;
                end
            end
            m_flags = (clr_exc ? 0 : m_flags) | nw;
            if (cw_wr) m_mask = cw_mask;
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        insn_done = 0; exc_req = 0; is_ctrl = 0; has_opnd = 0;
        cw_wr = 0; clr_exc = 0; host_esc = 0;
    endtask

    task automatic issue(input logic [5:0] req, input logic ctrl, input logic [19:0] ia,
                         input logic [10:0] op, input logic ho, input logic [19:0] da);
        idle();
        insn_done = 1; exc_req = req; is_ctrl = ctrl;
        insn_addr = ia; insn_opc = op; has_opnd = ho; opnd_addr = da;
        tick();
        idle();
    endtask

    task automatic set_mask(input logic [5:0] m);
        idle(); cw_wr = 1; cw_mask = m; tick(); idle();
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        insn_addr = 0; insn_opc = 0; opnd_addr = 0; cw_mask = 0;
        rst = 1;
        @(negedge clk);
        tick(); tick();
        rst = 0;
        // R1 reset state
        check("R1 reset flags", int'(status_o), 0);
        check("R1 reset mask", int'(mask_o), 'h3f);
        check("R1 reset err_n", int'(err_n), 1);
        check("R1 reset ptr", int'({ip_hi, ip_lo, dp_hi, dp_lo}), 0);

        // R4 masked request: flag set, no error
        issue(6'b100000, 0, 20'hA1234, 11'h5A5, 1, 20'h3BEEF);
        check("R4 masked flag", int'(status_o[5]), 1);
        check("R4 no error", int'(err_n), 1);
        check("R9 ip_hi split", int'(ip_hi), 'hA);
        check("R9 dp_lo split", int'(dp_lo), 'hBEEF);

        // R8 escape without pending error
        idle(); host_esc = 1; tick(); idle(); tick();
        check("R8 no int16", int'(int16), 0);

        // R7 unmasking an existing flag raises error immediately
        set_mask(6'h1f);
        check("R7 unmask raises", int'(err_n), 0);
        set_mask(6'h3f);
        check("R7 remask clears", int'(err_n), 1);

        // R3 precedence: all unmasked, request overflow+zero-divide+precision
        idle(); clr_exc = 1; tick(); idle();
        check("R6 clear", int'(status_o[5:0]), 0);
        set_mask(6'h00);
        issue(6'b101100, 0, 20'h00010, 11'h001, 0, 20'hFFFFF);
        check("R3 zdiv only", int'(status_o[5:0]), 'b000100);
        check("R5 es set", int'(status_o[7]), 1);
        check("R9 dp zero no opnd", int'({dp_hi, dp_lo}), 0);

        // R8 escape with pending error
        idle(); host_esc = 1; tick();
        check("R8 int16 raised", int'(int16), 1);
        idle(); tick();
        check("R8 int16 one cycle", int'(int16), 0);

        // R10 control instruction keeps pointers
        issue(6'b000001, 1, 20'h77777, 11'h7FF, 1, 20'h12345);
        check("R10 ip held", int'({ip_hi, ip_lo}), 'h00010);
        check("R3 invalid recorded", int'(status_o[0]), 1);

        // R6 clear and request in same cycle
        idle(); clr_exc = 1; insn_done = 1; exc_req = 6'b010000; insn_addr = 20'h4;
        tick(); idle();
        check("R6 clear plus new", int'(status_o[5:0]), 'b010000);

        // random phase
        for (int n = 0; n < 3000; n++) begin
            idle();
            insn_done = ($urandom_range(0, 2) != 0);
            exc_req   = 6'($urandom_range(0, 63));
            is_ctrl   = ($urandom_range(0, 3) == 0);
            has_opnd  = $urandom_range(0, 1) != 0;
            insn_addr = 20'($urandom());
            opnd_addr = 20'($urandom());
            insn_opc  = 11'($urandom());
            cw_wr     = ($urandom_range(0, 7) == 0);
            cw_mask   = 6'($urandom_range(0, 63));
            clr_exc   = ($urandom_range(0, 9) == 0);
            host_esc  = ($urandom_range(0, 3) == 0);
            tick();
        end
        idle();
        tick();

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule